// File: doc/BRIEF.md
# Interrupt Mask Duration Monitor

This block measures how long a processor's interrupt mask bit stays set. The mask bit is sampled only when a sample strobe is high, which is normally once per instruction boundary. The timing comes from a free-running cycle count that is supplied from outside. A masked interval opens on the first strobed sample that shows the bit set. It closes on the first strobed sample that shows the bit clear. The closing length is the cycle count minus the recorded start, taken modulo the counter width.

The block keeps three values: the shortest completed interval, the longest completed interval, and the most recently completed interval. While an interval is still open, its running length is visible on an output. A one-cycle query pulse merges that running length into the longest value when the running length is larger. The minimum register starts at an all-ones sentinel, which means "nothing recorded yet". The reported minimum falls back to the maximum while that sentinel is still in place.

One instance watches the maskable-interrupt mask bit. A second instance watches the non-maskable-line mask bit.

Top module: `mask_span_monitor`

## Requirements
- R1: A strobed sample with the mask set while no interval is open records `cycle_i` as the start, and `open_o` is high from the next cycle. While open, `run_len_o` shows `cycle_i` minus the start. When no interval is open, `run_len_o` is 0.
- R2: A strobed sample with the mask clear while an interval is open closes the interval. The duration is `cycle_i` minus the start, modulo 2^CW, and `open_o` is low from the next cycle.
- R3: Every closing duration is written to `last_o`.
- R4: A closing duration is written to `min_o` when it is smaller than `min_o`, and to `max_o` when it is larger than `max_o`.
- R5: While `rst_n` is low, `min_o` is all ones, `max_o` and `last_o` are 0, and `open_o` is 0.
- R6: `rpt_min_o` equals `max_o` while `min_o` is all ones, and equals `min_o` otherwise.
- R7: A high `query_i` while an interval is open, and not closing in that cycle, writes `run_len_o` to `max_o` when it is larger. A query with no open interval changes nothing.
- R8: When `sample_i` is low, changes on `mask_i` are ignored.
- R9: Durations and running lengths saturate at all ones minus 1 and never reach the sentinel value.
- R10: A strobed set sample while an interval is already open does not move the start. A strobed clear sample while no interval is open changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_i | input | 1 | Strobe that qualifies `mask_i` |
| mask_i | input | 1 | Mask bit being measured |
| cycle_i | input | CW | Free-running cycle count |
| query_i | input | 1 | Merges the open interval's length into the maximum |
| min_o | output | CW | Shortest completed interval (all ones if none) |
| max_o | output | CW | Longest interval |
| last_o | output | CW | Most recent completed interval |
| open_o | output | 1 | An interval is in progress |
| run_len_o | output | CW | Running length of the open interval |
| rpt_min_o | output | CW | Minimum for reporting, with the sentinel replaced by the maximum |

## Verification
The bench builds the block with CW = 16. Because `cycle_i` is driven directly, a 16-bit width brings two cases within a few cycles: a counter wrap inside an open interval, and a difference that lands exactly on the all-ones sentinel and so must saturate. The same width keeps the expected minimum, maximum and last values small enough to read in the vector table.

// File: rtl/mask_span_pkg.sv
package mask_span_pkg;
  // Kind of update applied to the statistics registers in a cycle
  typedef enum logic [1:0] {
    UPD_NONE  = 2'd0,
    UPD_CLOSE = 2'd1,
    UPD_FOLD  = 2'd2
  } upd_kind_e;
endpackage

// File: rtl/mspan_tracker.sv
module mspan_tracker #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample_i,
  input  logic          mask_i,
  input  logic [CW-1:0] cycle_i,
  output logic          open_o,
  output logic [CW-1:0] run_len_o,
  output logic          close_o
);
  localparam logic [CW-1:0] SENT = {CW{1'b1}};
  localparam logic [CW-1:0] CAP  = SENT - 1'b1;

  logic          open_q, open_d;
  logic [CW-1:0] start_q;
  logic          start_en;
  logic [CW-1:0] diff;

  assign diff      = cycle_i - start_q;
  assign run_len_o = open_q ? ((diff == SENT) ? CAP : diff) : '0;
  assign open_o    = open_q;
  assign close_o   = sample_i & ~mask_i & open_q;
  assign start_en  = sample_i & mask_i & ~open_q;

  always_comb begin
    open_d = open_q;
    if (start_en)     open_d = 1'b1;
    else if (close_o) open_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) open_q <= 1'b0;
    else        open_q <= open_d;
  end

  always_ff @(posedge clk) begin
    if (start_en) start_q <= cycle_i;
  end

  // R1: opening records the current cycle as start
  a_r1_open_start: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_i && mask_i && !open_q) |=> (open_q && start_q == $past(cycle_i)));
  // R2: a strobed clear sample ends the open interval
  a_r2_close: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_i && !mask_i && open_q) |=> !open_q);
  // R10: a set sample during an open interval keeps the start
  a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_i && mask_i && open_q) |=> (open_q && $stable(start_q)));
  // R8: without the strobe the open state holds
  a_r8_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_i |=> $stable(open_q));
  // R9: running length never reaches the sentinel
  a_r9_sat: assert property (@(posedge clk) disable iff (!rst_n)
    run_len_o != SENT);
endmodule

// File: rtl/mspan_stats.sv
module mspan_stats
  import mask_span_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  upd_kind_e     kind_i,
  input  logic [CW-1:0] len_i,
  output logic [CW-1:0] min_o,
  output logic [CW-1:0] max_o,
  output logic [CW-1:0] last_o
);
  localparam logic [CW-1:0] SENT = {CW{1'b1}};

  logic [CW-1:0] min_q, max_q, last_q;
  logic          min_en, max_en, last_en;

  always_comb begin
    min_en  = (kind_i == UPD_CLOSE) && (len_i < min_q);
    last_en = (kind_i == UPD_CLOSE);
    max_en  = (kind_i != UPD_NONE) && (len_i > max_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      min_q  <= SENT;
      max_q  <= '0;
      last_q <= '0;
    end else begin
      if (min_en)  min_q  <= len_i;
      if (max_en)  max_q  <= len_i;
      if (last_en) last_q <= len_i;
    end
  end

  assign min_o  = min_q;
  assign max_o  = max_q;
  assign last_o = last_q;

  // R3: a close always updates last
  a_r3_last: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_i == UPD_CLOSE) |=> (last_q == $past(len_i)));
  // R4: once a minimum exists it never exceeds the maximum
  a_r4_order: assert property (@(posedge clk) disable iff (!rst_n)
    (min_q != SENT) |-> (min_q <= max_q));
  // R7: max never decreases
  a_r7_max_mono: assert property (@(posedge clk) disable iff (!rst_n)
    max_q >= $past(max_q));
  // R8: no update leaves all statistics alone
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_i == UPD_NONE) |=> ($stable(min_q) && $stable(max_q) && $stable(last_q)));
endmodule

// File: rtl/mask_span_monitor.sv
module mask_span_monitor
  import mask_span_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample_i,
  input  logic          mask_i,
  input  logic [CW-1:0] cycle_i,
  input  logic          query_i,
  output logic [CW-1:0] min_o,
  output logic [CW-1:0] max_o,
  output logic [CW-1:0] last_o,
  output logic          open_o,
  output logic [CW-1:0] run_len_o,
  output logic [CW-1:0] rpt_min_o
);
  localparam logic [CW-1:0] SENT = {CW{1'b1}};

  logic      close_w;
  upd_kind_e kind_w;

  mspan_tracker #(.CW(CW)) u_trk (
    .clk(clk), .rst_n(rst_n), .sample_i(sample_i), .mask_i(mask_i),
    .cycle_i(cycle_i), .open_o(open_o), .run_len_o(run_len_o), .close_o(close_w)
  );

  // A close takes precedence over a query in the same cycle
  always_comb begin
    if (close_w)                kind_w = UPD_CLOSE;
    else if (query_i && open_o) kind_w = UPD_FOLD;
    else                        kind_w = UPD_NONE;
  end

  mspan_stats #(.CW(CW)) u_sts (
    .clk(clk), .rst_n(rst_n), .kind_i(kind_w), .len_i(run_len_o),
    .min_o(min_o), .max_o(max_o), .last_o(last_o)
  );

  assign rpt_min_o = (min_o == SENT) ? max_o : min_o;

  // R6: report value never shows the sentinel unless max does
  a_r6_rpt: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_min_o == SENT) |-> (max_o == SENT));
endmodule

// File: tb/mask_span_monitor_bench.sv
module mask_span_monitor_bench;
  localparam int CW = 16;
  localparam logic [CW-1:0] SENT = {CW{1'b1}};

  typedef struct packed {
    logic          s;
    logic          m;
    logic          q;
    logic [CW-1:0] c;
    logic          eo;
    logic [CW-1:0] emin;
    logic [CW-1:0] emax;
    logic [CW-1:0] elast;
    logic [CW-1:0] erun;
  } vec_t;

  function automatic vec_t mk(logic s, logic m, logic q, int c, logic eo,
                              int emin, int emax, int elast, int erun);
    vec_t v;
    v.s = s; v.m = m; v.q = q; v.c = CW'(c); v.eo = eo;
    v.emin = CW'(emin); v.emax = CW'(emax); v.elast = CW'(elast); v.erun = CW'(erun);
    return v;
  endfunction

  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    mk(1,1,0,100,   1,'hFFFF,  0,  0, 0),   // R1 open
    mk(1,1,0,110,   1,'hFFFF,  0,  0,10),   // R10 no restart
    mk(0,0,0,120,   1,'hFFFF,  0,  0,20),   // R8 unstrobed clear ignored
    mk(1,0,0,130,   0,     30, 30, 30, 0),  // R2 R3 R4 close 30
    mk(1,0,0,140,   0,     30, 30, 30, 0),  // R10 clear when closed
    mk(1,1,0,200,   1,     30, 30, 30, 0),  // R1
    mk(0,0,1,250,   1,     30, 50, 30,50),  // R7 fold
    mk(1,0,0,220,   0,     20, 50, 20, 0),  // R4 new min
    mk(1,1,0,300,   1,     20, 50, 20, 0),
    mk(1,0,0,400,   0,     20,100,100, 0),  // R4 new max
    mk(0,0,1,500,   0,     20,100,100, 0),  // R7 query when closed
    mk(1,1,0,'hFFF0,1,     20,100,100, 0),
    mk(1,0,0,'h0010,0,     20,100, 32, 0)   // R2 wrap
  };

  logic clk, rst_n, sample_i, mask_i, query_i;
  logic [CW-1:0] cycle_i, min_o, max_o, last_o, run_len_o, rpt_min_o;
  logic open_o;
  int checks = 0, fails = 0;
  logic done = 0;

  mask_span_monitor #(.CW(CW)) u_mask_span_monitor (
    .clk(clk), .rst_n(rst_n), .sample_i(sample_i), .mask_i(mask_i),
    .cycle_i(cycle_i), .query_i(query_i), .min_o(min_o), .max_o(max_o),
    .last_o(last_o), .open_o(open_o), .run_len_o(run_len_o), .rpt_min_o(rpt_min_o)
  );

  initial clk = 0;
  always #2 clk = ~clk;

  task automatic chk(string req, logic [CW-1:0] act, logic [CW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step(logic s, logic m, logic q, logic [CW-1:0] c);
    @(negedge clk);
    sample_i = s; mask_i = m; query_i = q; cycle_i = c;
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; sample_i = 0; mask_i = 0; query_i = 0; cycle_i = 0;
    #6;
    // R5 reset state
    chk("R5 min", min_o, SENT);
    chk("R5 max", max_o, '0);
    chk("R5 last", last_o, '0);
    chk("R5 open", {{(CW-1){1'b0}}, open_o}, '0);
    @(negedge clk); rst_n = 1;
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1; sample_i = 0; mask_i = 0; query_i = 0; cycle_i = 0;
    do_reset();
    for (int i = 0; i < NV; i++) begin
      step(TBL[i].s, TBL[i].m, TBL[i].q, TBL[i].c);
      chk("R1 R2 R10 open", {{(CW-1){1'b0}}, open_o}, {{(CW-1){1'b0}}, TBL[i].eo});
      chk("R4 min", min_o, TBL[i].emin);
      chk("R4 R7 max", max_o, TBL[i].emax);
      chk("R3 last", last_o, TBL[i].elast);
      chk("R1 run", run_len_o, TBL[i].erun);
      chk("R6 rpt", rpt_min_o, (TBL[i].emin == SENT) ? TBL[i].emax : TBL[i].emin);
    end

    // R6: sentinel min reports max after fold
    do_reset();
    step(1, 1, 0, 16'd0);
    step(0, 0, 1, 16'd40);
    chk("R7 fold max", max_o, 16'd40);
    chk("R6 sentinel rpt", rpt_min_o, 16'd40);
    chk("R6 min still sentinel", min_o, SENT);

    // R9: saturation of running length and of a closing duration
    do_reset();
    step(1, 1, 0, 16'd1);
    step(0, 1, 0, 16'd0);
    chk("R9 run sat", run_len_o, 16'hFFFE);
    step(1, 0, 0, 16'd0);
    chk("R9 last sat", last_o, 16'hFFFE);
    chk("R9 max sat", max_o, 16'hFFFE);
    chk("R9 min sat", min_o, 16'hFFFE);

    // R8: unstrobed set does not open
    step(0, 1, 0, 16'd5);
    chk("R8 no open", {{(CW-1){1'b0}}, open_o}, '0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule